// File: doc/BRIEF.md
# Sector Byte Streamer with Running Checksum

This block carries one disk sector across a memory-mapped window as a stream of single-byte accesses. A shared byte counter marks the position in the sector. Read accesses hand back the contents of a local sector buffer in ascending order. Once every data byte has been read, each further read returns an 8-bit checksum that was built up over those bytes.

Write accesses carry their byte in the low eight address bits instead of on a data bus. Each byte is placed at its position in the raw on-medium frame: a lead-in of zero bytes, the sync bytes, the data bytes, and one checksum slot. Only the data part of that frame is stored in the buffer. A one-cycle pulse marks the access that fills the frame. A clear strobe rewinds the counter between sectors.

A side port lets a test harness preload and inspect the buffer. While that port is active, it holds off bus accesses.

Top module: `sector_streamer`

## Requirements
- R1: After reset, acc_ack_o and wr_done_o are low, the byte counter is zero, and the first read returns buffer byte 0.
- R2: A read accepted while the counter k is below 512 returns buffer byte k and advances the counter by one.
- R3: The checksum register is zeroed by a read at counter zero. Each data byte b read then updates it as c = rotate-left-by-one(c XOR b), with bit 7 moving into bit 0. Every read at a counter of 512 or more returns the checksum.
- R4: An access is accepted when acc_valid_i is high, acc_ack_o is low and tp_en_i is low. acc_ack_o is high for exactly the one cycle after acceptance, and acc_rdata_o is valid in that cycle.
- R5: A write first advances the counter to k and then takes its byte from acc_addr_i. With a 32-byte zero lead-in and 2 sync bytes, raw indices 34 to 545 store into buffer entry k-34. Every other raw index is discarded.
- R6: wr_done_o pulses high together with acc_ack_o for the write that reaches raw index 546 (frame length 547 minus one), and for no other access.
- R7: clr_i zeroes the counter. If it comes in the same cycle as an accepted access, that access is served at the old count and the counter still ends at zero.
- R8: When drive_present_i is low, a read at counter zero returns 0xE5 and leaves the counter at zero. At any nonzero count, drive_present_i has no effect.
- R9: While tp_en_i is high, no bus access is accepted. The test port writes tp_wdata_i when tp_we_i is high. Otherwise it returns the addressed byte on tp_rdata_o in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | 1 = write window, 0 = read window |
| acc_addr_i | input | 8 | Low address bits; write data byte |
| drive_present_i | input | 1 | Selected drive is attached |
| clr_i | input | 1 | Clear byte counter strobe |
| acc_ack_o | output | 1 | Access acknowledge, one cycle |
| acc_rdata_o | output | 8 | Read data, valid with acknowledge |
| wr_done_o | output | 1 | Raw frame full pulse |
| tp_en_i | input | 1 | Test port owns the buffer |
| tp_we_i | input | 1 | Test port write enable |
| tp_addr_i | input | 9 | Test port buffer address |
| tp_wdata_i | input | 8 | Test port write byte |
| tp_rdata_o | output | 8 | Test port read byte, one cycle latency |

## Verification
Two things can happen in the same cycle. A counter clear can arrive together with an accepted read, and the test port can claim the buffer while a bus request is pending. The bench raises clr_i in the acceptance cycle of a read at count 5. It expects byte 5 back, and byte 0 from the next read. It also holds a bus read pending across several test-port cycles. In those cycles it expects no acknowledge and correct test-port data, and then an acknowledge carrying byte 0 once the test port lets go.

// File: rtl/sector_pkg.sv
package sector_pkg;
  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_CKS  = 2'd1,
    SRC_FILL = 2'd2,
    SRC_NONE = 2'd3
  } src_e;

  function automatic logic [7:0] cks_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    return {x[6:0], x[7]};
  endfunction
endpackage

// File: rtl/sector_ram.sv
module sector_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];
  logic [7:0] q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      q <= mem[addr_i];
    end
  end

  assign rdata_o = q;
endmodule

// File: rtl/sector_cksum.sv
module sector_cksum (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       upd_i,
  input  logic [7:0] byte_i,
  output logic [7:0] cks_o
);
  import sector_pkg::*;
  logic [7:0] cks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cks_q <= '0;
    else if (clear_i) cks_q <= '0;
    else if (upd_i)   cks_q <= cks_step(cks_q, byte_i);
  end

  assign cks_o = cks_q;
endmodule

// File: rtl/sector_ctl.sv
module sector_ctl
  import sector_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int LEAD_ZEROS = 32,
  parameter int SYNC_BYTES = 2,
  parameter int AW         = $clog2(DATA_BYTES),
  parameter int RAW_LEN    = LEAD_ZEROS + SYNC_BYTES + DATA_BYTES + 1,
  parameter int CNT_W      = $clog2(RAW_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [7:0]       acc_addr_i,
  input  logic             drive_present_i,
  input  logic             clr_i,
  input  logic             tp_en_i,
  output logic             ack_o,
  output logic             done_o,
  output src_e             src_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ram_en_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [7:0]       ram_wdata_o,
  output logic             cks_clear_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] DATA_C  = CNT_W'(DATA_BYTES);
  localparam logic [CNT_W-1:0] OFS_C   = CNT_W'(LEAD_ZEROS + SYNC_BYTES);
  localparam logic [CNT_W-1:0] END_C   = CNT_W'(LEAD_ZEROS + SYNC_BYTES + DATA_BYTES);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(RAW_LEN - 1);

  logic ack_q, done_q;
  src_e src_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic accept, is_zero, rd_acc, rd_fill, rd_data, wr_acc, wr_store;

  assign accept   = acc_valid_i & ~ack_q & ~tp_en_i;
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign is_zero  = (cnt_q == '0);
  assign rd_acc   = accept & ~acc_write_i;
  assign wr_acc   = accept & acc_write_i;
  assign rd_fill  = rd_acc & is_zero & ~drive_present_i;
  assign rd_data  = rd_acc & ~rd_fill & (cnt_q < DATA_C);
  // raw index is the incremented count
  assign wr_store = wr_acc & (cnt_inc >= OFS_C) & (cnt_inc < END_C);

  assign ram_en_o    = rd_data | wr_store;
  assign ram_we_o    = wr_store;
  assign ram_addr_o  = wr_store ? AW'(cnt_inc - OFS_C) : cnt_q[AW-1:0];
  assign ram_wdata_o = acc_addr_i;
  assign cks_clear_o = rd_acc & is_zero & drive_present_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      done_q <= 1'b0;
      src_q  <= SRC_NONE;
      cnt_q  <= '0;
    end else begin
      ack_q  <= accept;
      done_q <= wr_acc & (cnt_inc == LAST_C) & (cnt_q != LAST_C);
      if (accept) begin
        if (acc_write_i)  src_q <= SRC_NONE;
        else if (rd_fill) src_q <= SRC_FILL;
        else if (rd_data) src_q <= SRC_DATA;
        else              src_q <= SRC_CKS;
      end
      if (clr_i)                  cnt_q <= '0;
      else if (accept & ~rd_fill) cnt_q <= cnt_inc;
    end
  end

  assign ack_o  = ack_q;
  assign done_o = done_q;
  assign src_o  = src_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sector_streamer.sv
module sector_streamer
  import sector_pkg::*;
#(
  parameter int         DATA_BYTES = 512,
  parameter int         LEAD_ZEROS = 32,
  parameter int         SYNC_BYTES = 2,
  parameter logic [7:0] FILL_BYTE  = 8'hE5,
  parameter int         AW         = $clog2(DATA_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [7:0]    acc_addr_i,
  input  logic          drive_present_i,
  input  logic          clr_i,
  output logic          acc_ack_o,
  output logic [7:0]    acc_rdata_o,
  output logic          wr_done_o,
  input  logic          tp_en_i,
  input  logic          tp_we_i,
  input  logic [AW-1:0] tp_addr_i,
  input  logic [7:0]    tp_wdata_i,
  output logic [7:0]    tp_rdata_o
);
  localparam int RAW_LEN = LEAD_ZEROS + SYNC_BYTES + DATA_BYTES + 1;
  localparam int CNT_W   = $clog2(RAW_LEN + 1);

  src_e             src;
  logic [CNT_W-1:0] cnt;
  logic             c_en, c_we, cks_clear;
  logic [AW-1:0]    c_addr;
  logic [7:0]       c_wdata, ram_q, cks;

  sector_ctl #(
    .DATA_BYTES(DATA_BYTES), .LEAD_ZEROS(LEAD_ZEROS), .SYNC_BYTES(SYNC_BYTES), .AW(AW)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i), .acc_addr_i(acc_addr_i),
    .drive_present_i(drive_present_i), .clr_i(clr_i), .tp_en_i(tp_en_i),
    .ack_o(acc_ack_o), .done_o(wr_done_o), .src_o(src), .cnt_o(cnt),
    .ram_en_o(c_en), .ram_we_o(c_we), .ram_addr_o(c_addr), .ram_wdata_o(c_wdata),
    .cks_clear_o(cks_clear)
  );

  // test port owns the buffer while enabled; ctl never accepts then
  sector_ram #(.DEPTH(DATA_BYTES), .AW(AW)) u_ram (
    .clk_i(clk_i),
    .en_i(tp_en_i | c_en),
    .we_i(tp_en_i ? tp_we_i : c_we),
    .addr_i(tp_en_i ? tp_addr_i : c_addr),
    .wdata_i(tp_en_i ? tp_wdata_i : c_wdata),
    .rdata_o(ram_q)
  );

  sector_cksum u_cks (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(cks_clear),
    .upd_i(acc_ack_o & (src == SRC_DATA)),
    .byte_i(ram_q),
    .cks_o(cks)
  );

  always_comb begin
    unique case (src)
      SRC_DATA: acc_rdata_o = ram_q;
      SRC_CKS:  acc_rdata_o = cks;
      SRC_FILL: acc_rdata_o = FILL_BYTE;
      default:  acc_rdata_o = 8'h00;
    endcase
  end

  assign tp_rdata_o = ram_q;
endmodule

// File: rtl/sector_streamer_chk.sv
module sector_streamer_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic             acc_write_i,
  input logic             drive_present_i,
  input logic             clr_i,
  input logic             tp_en_i,
  input logic             acc_ack_o,
  input logic [7:0]       acc_rdata_o,
  input logic             wr_done_o,
  input logic [CNT_W-1:0] cnt_i
);
  logic acc_ok;
  assign acc_ok = acc_valid_i & ~acc_ack_o & ~tp_en_i;

  // R4
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ack_o |=> !acc_ack_o);
  // R4
  ack_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok |=> acc_ack_o);
  // R9
  tp_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tp_en_i && !acc_ack_o) |=> !acc_ack_o);
  // R6
  done_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> acc_ack_o);
  // R7
  clr_zeroes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_i == '0));
  // R8
  absent_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && !acc_write_i && !drive_present_i && cnt_i == '0 && !clr_i)
      |=> (cnt_i == '0 && acc_rdata_o == 8'hE5));
  // R2
  rd_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && !acc_write_i && cnt_i != '0 && cnt_i < CNT_W'(512) && !clr_i)
      |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));
endmodule

bind sector_streamer sector_streamer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
  .drive_present_i(drive_present_i), .clr_i(clr_i), .tp_en_i(tp_en_i),
  .acc_ack_o(acc_ack_o), .acc_rdata_o(acc_rdata_o), .wr_done_o(wr_done_o), .cnt_i(cnt)
);

// File: tb/sector_streamer_tb.sv
module sector_streamer_tb;
  localparam int CLK_P = 10;
  localparam int N     = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, drive_present = 1, clr = 0;
  logic [7:0] acc_addr = '0;
  logic acc_ack, wr_done;
  logic [7:0] acc_rdata, tp_rdata;
  logic tp_en = 0, tp_we = 0;
  logic [8:0] tp_addr = '0;
  logic [7:0] tp_wdata = '0;

  int tests = 0, fails = 0;
  logic [7:0] mem [N];

  always #(CLK_P/2) clk = ~clk;

  sector_streamer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_addr_i(acc_addr), .drive_present_i(drive_present), .clr_i(clr),
    .acc_ack_o(acc_ack), .acc_rdata_o(acc_rdata), .wr_done_o(wr_done),
    .tp_en_i(tp_en), .tp_we_i(tp_we), .tp_addr_i(tp_addr), .tp_wdata_i(tp_wdata),
    .tp_rdata_o(tp_rdata)
  );

  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    return {x[6:0], x[7]};
  endfunction

  function automatic logic [7:0] ref_cks();
    logic [7:0] c = 8'h00;
    for (int i = 0; i < N; i++) c = ref_step(c, mem[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // one bus access; returns data and done sampled in the ack cycle
  task automatic bus(input bit wr, input logic [7:0] a, input bit with_clr,
                     output logic [7:0] d, output logic dn, output logic ak);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_addr = a; clr = with_clr;
    @(negedge clk);
    acc_valid = 0; clr = 0;
    ak = acc_ack; d = acc_rdata; dn = wr_done;
  endtask

  task automatic rd(output logic [7:0] d);
    logic dn, ak;
    bus(1'b0, 8'h00, 1'b0, d, dn, ak);
  endtask

  task automatic clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic tp_load();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      mem[i] = 8'($urandom);
      tp_en = 1; tp_we = 1; tp_addr = 9'(i); tp_wdata = mem[i];
    end
    @(negedge clk); tp_en = 0; tp_we = 0;
  endtask

  task automatic tp_read(input int a, output logic [7:0] d);
    @(negedge clk); tp_en = 1; tp_we = 0; tp_addr = 9'(a);
    @(negedge clk); d = tp_rdata; tp_en = 0;
  endtask

  task automatic read_sector(input string tag);
    logic [7:0] d;
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      rd(d);
      // R2 data byte i at count i
      chk(d == mem[i], "R2", d, mem[i]);
    end
    rd(d);
    chk(d == ref_cks(), "R3", d, ref_cks());
    rd(d);
    chk(d == ref_cks(), "R3 repeat", d, ref_cks());
    bad = bad;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] d, wb;
    logic dn, ak;
    logic [7:0] raw [547];
    void'($urandom(32'd20240611));

    #(CLK_P * 3);
    @(negedge clk);
    // R1 reset state
    chk(acc_ack == 0 && wr_done == 0, "R1", {acc_ack, wr_done}, 0);
    rst_n = 1;

    tp_load();
    rd(d);
    chk(d == mem[0], "R1 first read", d, mem[0]);
    clear();
    read_sector("a");

    // R4 ack single cycle
    clear();
    bus(1'b0, 8'h00, 1'b0, d, dn, ak);
    chk(ak == 1, "R4 ack", ak, 1);
    @(negedge clk);
    chk(acc_ack == 0, "R4 ack drops", acc_ack, 0);

    // second pattern: fresh data, directed extremes
    tp_load();
    clear();
    read_sector("b");

    // R7 clear in same cycle as read at count 5
    clear();
    for (int i = 0; i < 5; i++) rd(d);
    bus(1'b0, 8'h00, 1'b1, d, dn, ak);
    chk(d == mem[5], "R7 old count", d, mem[5]);
    rd(d);
    chk(d == mem[0], "R7 rewound", d, mem[0]);

    // R8 absent drive
    clear();
    drive_present = 0;
    rd(d);
    chk(d == 8'hE5, "R8 fill", d, 8'hE5);
    rd(d);
    chk(d == 8'hE5, "R8 count held", d, 8'hE5);
    drive_present = 1;
    rd(d);
    chk(d == mem[0], "R8 present", d, mem[0]);
    drive_present = 0;
    rd(d);
    chk(d == mem[1], "R8 ignored nonzero", d, mem[1]);
    drive_present = 1;

    // R5 / R6 frame write; random bytes, directed zeros in lead-in
    clear();
    for (int k = 1; k <= 546; k++) begin
      wb = (k <= 32) ? 8'h00 : 8'($urandom);
      raw[k] = wb;
      bus(1'b1, wb, 1'b0, d, dn, ak);
      if (k >= 540 || k <= 2) chk(dn == (k == 546), "R6 done", dn, k == 546);
      else if (dn) chk(1'b0, "R6 early done", k, 546);
    end
    for (int i = 0; i < N; i++) mem[i] = raw[34 + i];
    for (int i = 0; i < N; i++) begin
      tp_read(i, d);
      chk(d == mem[i], "R5 stored", d, mem[i]);
    end
    bus(1'b1, 8'hA5, 1'b0, d, dn, ak);
    chk(dn == 0, "R6 no repeat", dn, 0);
    tp_read(0, d);
    chk(d == mem[0], "R5 discard", d, mem[0]);
    tp_read(N - 1, d);
    chk(d == mem[N-1], "R5 discard end", d, mem[N-1]);

    // R3 checksum over written sector
    clear();
    read_sector("c");

    // R9 test port holds off pending bus read
    clear();
    @(negedge clk);
    tp_en = 1; tp_we = 0; tp_addr = 9'd3; acc_valid = 1; acc_write = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(acc_ack == 0, "R9 blocked", acc_ack, 0);
    end
    chk(tp_rdata == mem[3], "R9 tp read", tp_rdata, mem[3]);
    tp_en = 0;
    @(negedge clk);
    acc_valid = 0;
    chk(acc_ack == 1 && acc_rdata == mem[0], "R9 released", acc_rdata, mem[0]);
    @(negedge clk);
    chk(acc_ack == 0, "R4 single", acc_ack, 0);

    summary();
  end
endmodule